// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block walks a byte-wide program memory from a start address that is presented on an input while reset is held. The first byte of each instruction is taken as the opcode. The sequencer decodes from that byte whether zero, one or two further bytes belong to the instruction. It reads exactly that many following bytes as operand data. When the last byte is in, it hands the complete instruction to a downstream executor as one registered bundle: opcode, length, a 16-bit operand and an unsupported-opcode flag.

A byte counts as data only because of where it sits after an opcode, never because of its value. The same value 0x06 is an opcode in one place and an immediate in another. The unconditional jump opcode reloads the program counter from its own operand, so the sequencer follows it without help from the executor. An external redirect input also reloads the counter and drops any instruction that is only partly fetched. A busy input from the consumer holds off new memory reads.

Top module: `ifs_fetch_seq`

## Requirements
- R1: While `rst` is high, `mem_rd` and `instr_valid` are 0. The first read after reset is released goes to the `start_addr` value that was sampled during reset.
- R2: Each read is a one-cycle `mem_rd` pulse, and the byte is taken from `mem_data` in the next cycle. Consecutive reads go to consecutive addresses, and two reads are never in adjacent cycles.
- R3: Opcodes of the form 00 ddd 110 with ddd in {111, 000, 001} (0x3E, 0x06, 0x0E) are two bytes long. They report `instr_len`=2, with the second byte in `instr_operand[7:0]` and zeros above it.
- R4: Opcode 0x2F and the moves 01 ddd sss with both ddd and sss in {111, 000, 001} are one byte long. They report `instr_len`=1, `instr_operand`=0 and `illegal_op`=0.
- R5: Opcodes 0x3A and 0xC3 are three bytes long. They report `instr_len`=3 with `instr_operand` = {third byte, second byte}, so the low byte comes first in memory.
- R6: After opcode 0xC3 completes, the next read goes to its 16-bit operand, and that address is already on `mem_addr` in the cycle where `instr_valid` is high.
- R7: Any other opcode is reported as one byte long with `instr_operand`=0 and `illegal_op`=1. The next byte is then fetched as an opcode.
- R8: `instr_valid` is high for exactly one cycle. It rises two cycles after the read of the instruction's last byte, so a one-byte instruction at the start address appears in cycle 2 after reset and a three-byte one in cycle 6.
- R9: No read is issued in a cycle where `busy` is high. Fetching resumes afterwards without losing or repeating a byte.
- R10: In a cycle with `redirect_valid` high, no read is issued and any partly fetched instruction is dropped. The next read goes to `redirect_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_addr | input | 16 | Address of the first opcode, sampled while in reset |
| mem_rd | output | 1 | Read strobe to the program memory |
| mem_addr | output | 16 | Read address (current program counter) |
| mem_data | input | 8 | Byte returned one cycle after `mem_rd` |
| busy | input | 1 | Consumer back-pressure; holds off reads |
| redirect_valid | input | 1 | Reload the program counter and drop a partial instruction |
| redirect_addr | input | 16 | New fetch address for a redirect |
| instr_valid | output | 1 | One-cycle strobe for a complete instruction |
| instr_op | output | 8 | Opcode byte |
| instr_len | output | 2 | Instruction length in bytes (1, 2 or 3) |
| instr_operand | output | 16 | Immediate (low byte) or 16-bit operand |
| illegal_op | output | 1 | Opcode outside the supported set |

## Verification
The bench walks the program image itself to predict every read address and every instruction, then compares them cycle by cycle. It places an unsupported two-byte-looking opcode directly before a byte that must then be taken as an opcode. It places 0x06 both as an opcode and as an immediate. A decoder that guessed roles from values, or that gave unsupported opcodes a length other than one, would shift the stream out of step, and every later address would mismatch. A jump assembled high byte first would fetch from the wrong place. A redirect that arrives while the low operand byte of a three-byte instruction is being captured must leave no trace of that instruction. A busy window must not drop or repeat bytes. Measuring first-strobe latency for one-byte and three-byte instructions catches an extra or missing pipeline register.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

    localparam int BYTE_W     = 8;
    localparam int OPND_BYTES = 2;
    localparam int ADDR_W     = BYTE_W * OPND_BYTES;
    localparam int LEN_W      = $clog2(OPND_BYTES + 2);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LEN_W-1:0]  len_t;

    localparam len_t LEN_ONE   = len_t'(1);
    localparam len_t LEN_TWO   = len_t'(2);
    localparam len_t LEN_THREE = len_t'(3);

    localparam byte_t OP_LOAD_DIRECT = 8'h3A;
    localparam byte_t OP_JUMP        = 8'hC3;
    localparam byte_t OP_INVERT_ACC  = 8'h2F;

    // register codes carried in opcode fields
    localparam logic [2:0] RC_ACC = 3'b111;
    localparam logic [2:0] RC_B   = 3'b000;
    localparam logic [2:0] RC_C   = 3'b001;

    typedef enum logic {ST_ISSUE, ST_CAPT} fstate_e;

    typedef struct packed {
        len_t len;
        logic bad;
    } klass_t;

    typedef struct packed {
        byte_t op;
        len_t  len;
        addr_t operand;
        logic  bad;
    } instr_t;

    function automatic logic known_reg(input logic [2:0] code);
        return (code == RC_ACC) || (code == RC_B) || (code == RC_C);
    endfunction

    function automatic klass_t classify(input byte_t op);
        klass_t k;
        k.len = LEN_ONE;
        k.bad = 1'b0;
        if (op == OP_LOAD_DIRECT || op == OP_JUMP) begin
            k.len = LEN_THREE;
        end else if (op[7:6] == 2'b00 && op[2:0] == 3'b110 && known_reg(op[5:3])) begin
            k.len = LEN_TWO;
        end else if (op == OP_INVERT_ACC) begin
            k.bad = 1'b0;
        end else if (op[7:6] == 2'b01 && known_reg(op[5:3]) && known_reg(op[2:0])) begin
            k.bad = 1'b0;
        end else begin
            k.bad = 1'b1;
        end
        return k;
    endfunction

endpackage

// File: rtl/ifs_len_decode.sv
module ifs_len_decode
    import ifs_pkg::*;
(
    input  byte_t opcode,
    output len_t  len,
    output logic  bad
);
    klass_t k;
    assign k   = classify(opcode);
    assign len = k.len;
    assign bad = k.bad;
endmodule

// File: rtl/ifs_pc.sv
module ifs_pc
    import ifs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  addr_t start_addr,
    input  logic  load,
    input  addr_t load_addr,
    input  logic  step,
    output addr_t pc
);
    always_ff @(posedge clk) begin
        if (rst)       pc <= start_addr;
        else if (load) pc <= load_addr;
        else if (step) pc <= addr_t'(pc + 1'b1);
    end

    // R10
    load_follow_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (pc == $past(load_addr)));
endmodule

// File: rtl/ifs_fetch_seq.sv
module ifs_fetch_seq
    import ifs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] start_addr,
    output logic        mem_rd,
    output logic [15:0] mem_addr,
    input  logic [7:0]  mem_data,
    input  logic        busy,
    input  logic        redirect_valid,
    input  logic [15:0] redirect_addr,
    output logic        instr_valid,
    output logic [7:0]  instr_op,
    output logic [1:0]  instr_len,
    output logic [15:0] instr_operand,
    output logic        illegal_op
);
    fstate_e state;
    len_t    idx, cur_len, len_now, dec_len;
    logic    dec_bad, fetch_go, capt_en, last_byte, jump_done, pc_load;
    addr_t   pc, pc_src, opnd_next, lanes_q;
    byte_t   op_q;
    logic    bad_q, valid_q;
    instr_t  out_q;

    ifs_len_decode u_dec (
        .opcode (mem_data),
        .len    (dec_len),
        .bad    (dec_bad)
    );

    assign len_now   = (idx == '0) ? dec_len : cur_len;
    assign fetch_go  = !rst && (state == ST_ISSUE) && !busy && !redirect_valid;
    assign capt_en   = (state == ST_CAPT) && !redirect_valid;
    assign last_byte = capt_en && (len_t'(idx + LEN_ONE) == len_now);
    assign jump_done = last_byte && (idx != '0) && (op_q == OP_JUMP);
    assign pc_load   = redirect_valid || jump_done;
    assign pc_src    = redirect_valid ? redirect_addr : opnd_next;

    ifs_pc u_pc (
        .clk        (clk),
        .rst        (rst),
        .start_addr (start_addr),
        .load       (pc_load),
        .load_addr  (pc_src),
        .step       (fetch_go),
        .pc         (pc)
    );

    // operand lanes: byte arriving now overrides the stored one, lanes past the length read zero
    for (genvar g = 0; g < OPND_BYTES; g++) begin : g_lane
        assign opnd_next[g*BYTE_W +: BYTE_W] =
            (len_t'(g + 1) >= len_now) ? '0 :
            (idx == len_t'(g + 1))     ? mem_data :
                                         lanes_q[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lanes_q <= '0;
        end else if (capt_en) begin
            for (int i = 0; i < OPND_BYTES; i++) begin
                if (idx == len_t'(i + 1)) lanes_q[i*BYTE_W +: BYTE_W] <= mem_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_ISSUE;
            idx     <= '0;
            cur_len <= LEN_ONE;
            op_q    <= '0;
            bad_q   <= 1'b0;
            valid_q <= 1'b0;
            out_q   <= '0;
        end else begin
            valid_q <= 1'b0;
            if (redirect_valid) begin
                state <= ST_ISSUE;
                idx   <= '0;
            end else begin
                case (state)
                    ST_ISSUE: if (fetch_go) state <= ST_CAPT;
                    ST_CAPT: begin
                        state <= ST_ISSUE;
                        if (idx == '0) begin
                            op_q    <= mem_data;
                            cur_len <= dec_len;
                            bad_q   <= dec_bad;
                        end
                        if (last_byte) begin
                            idx           <= '0;
                            valid_q       <= 1'b1;
                            out_q.op      <= (idx == '0) ? mem_data : op_q;
                            out_q.len     <= len_now;
                            out_q.operand <= opnd_next;
                            out_q.bad     <= (idx == '0) ? dec_bad : bad_q;
                        end else begin
                            idx <= len_t'(idx + LEN_ONE);
                        end
                    end
                    default: state <= ST_ISSUE;
                endcase
            end
        end
    end

    assign mem_rd        = fetch_go;
    assign mem_addr      = pc;
    assign instr_valid   = valid_q;
    assign instr_op      = out_q.op;
    assign instr_len     = out_q.len;
    assign instr_operand = out_q.operand;
    assign illegal_op    = out_q.bad;

    // R1
    always @(posedge clk) begin
        if (rst) reset_quiet_chk: assert (!mem_rd && !instr_valid);
    end

    // R2
    single_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        instr_valid |=> !instr_valid);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !mem_rd);

    // R10
    redirect_target_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> (mem_addr == $past(redirect_addr)));

    // R6
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_op == OP_JUMP) |-> (mem_addr == instr_operand));

    // R3
    narrow_operand_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_len == 2'd2) |-> (instr_operand[15:8] == 8'h00));
endmodule

// File: tb/ifs_fetch_seq_tb_top.sv
`timescale 1ns/100ps
module ifs_fetch_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] start_addr = 16'h2000;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data = 8'h00;
    logic        busy = 1'b0;
    logic        redirect_valid = 1'b0;
    logic [15:0] redirect_addr = 16'h0000;
    logic        instr_valid;
    logic [7:0]  instr_op;
    logic [1:0]  instr_len;
    logic [15:0] instr_operand;
    logic        illegal_op;

    always #2 clk = ~clk;

    ifs_fetch_seq dut_i (
        .clk(clk), .rst(rst), .start_addr(start_addr),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
        .busy(busy), .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
        .instr_valid(instr_valid), .instr_op(instr_op), .instr_len(instr_len),
        .instr_operand(instr_operand), .illegal_op(illegal_op)
    );

    logic [7:0] mem [256];
    always @(posedge clk) if (mem_rd) mem_data <= mem[mem_addr[7:0]];

    typedef struct {
        logic [7:0]  op;
        int          len;
        logic [15:0] opnd;
        bit          ill;
    } exp_t;

    exp_t        iq[$];
    logic [15:0] aq[$];
    string       tq[$];

    int total = 0;
    int bad   = 0;
    int got   = 0;
    int cyc_n = 0;
    int first_v = -1;
    bit mon_on = 0;
    bit prev_v = 0;
    logic [15:0] last_addr = 16'hFFFF;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
        end
    endtask

    // reference classification written as an explicit opcode list
    function automatic void ref_class(input logic [7:0] op, output int len, output bit ill);
        ill = 0;
        case (op)
            8'h3E, 8'h06, 8'h0E:                       len = 2;
            8'h3A, 8'hC3:                              len = 3;
            8'h2F, 8'h7F, 8'h78, 8'h79, 8'h47, 8'h40,
            8'h41, 8'h4F, 8'h48, 8'h49:                len = 1;
            default: begin len = 1; ill = 1; end
        endcase
    endfunction

    task automatic build(input logic [15:0] from, input int n, input string first_tag);
        logic [15:0] p;
        string tag;
        aq.delete(); tq.delete(); iq.delete();
        p = from;
        tag = first_tag;
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.op = mem[p[7:0]];
            aq.push_back(p); tq.push_back(tag); tag = "R2";
            p++;
            ref_class(e.op, e.len, e.ill);
            e.opnd = 16'h0000;
            if (e.len >= 2) begin
                aq.push_back(p); tq.push_back("R2");
                e.opnd[7:0] = mem[p[7:0]]; p++;
            end
            if (e.len == 3) begin
                aq.push_back(p); tq.push_back("R2");
                e.opnd[15:8] = mem[p[7:0]]; p++;
            end
            iq.push_back(e);
            if (e.op == 8'hC3) begin
                p = e.opnd;
                tag = "R6";
            end
        end
    endtask

    task automatic cyc();
        #1;
        if (mon_on) begin
            if (busy) chk(!mem_rd, "R9", "read during busy", {31'd0, mem_rd}, 32'd0);
            if (redirect_valid) chk(!mem_rd, "R10", "read during redirect", {31'd0, mem_rd}, 32'd0);
            if (mem_rd) begin
                logic [15:0] ea;
                string t;
                ea = aq.pop_front();
                t  = tq.pop_front();
                chk(mem_addr == ea, t, "read address", {16'd0, mem_addr}, {16'd0, ea});
                last_addr = mem_addr;
            end
            if (instr_valid) begin
                exp_t  e;
                string t;
                logic [31:0] act, expv;
                chk(!prev_v, "R8", "strobe longer than one cycle", 32'd1, 32'd0);
                e = iq.pop_front();
                t = (e.len == 3) ? "R5" : (e.len == 2) ? "R3" : e.ill ? "R7" : "R4";
                act  = {5'd0, instr_op, instr_len, instr_operand, illegal_op};
                expv = {5'd0, e.op, 2'(e.len), e.opnd, e.ill};
                chk(act == expv, t, "instruction {op,len,operand,illegal}", act, expv);
                got++;
                if (first_v < 0) first_v = cyc_n;
            end
            prev_v = instr_valid;
            cyc_n++;
        end
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [15:0] s);
        mon_on = 0;
        rst = 1; start_addr = s; busy = 0; redirect_valid = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            chk(!mem_rd && !instr_valid, "R1", "quiet in reset",
                {30'd0, mem_rd, instr_valid}, 32'd0);
        end
        @(negedge clk);
        rst = 0;
        got = 0; cyc_n = 0; first_v = -1; prev_v = 0; last_addr = 16'hFFFF;
    endtask

    task automatic run_main();
        // phase 1: mixed stream, jump, unsupported opcodes, busy window
        do_reset(16'h2000);
        build(16'h2000, 60, "R1");
        mon_on = 1;
        while (got < 12) cyc();
        busy = 1;
        for (int k = 0; k < 6; k++) cyc();
        busy = 0;
        while (got < 30) cyc();

        // phase 2: redirect while the low operand byte of a three-byte op is captured
        do_reset(16'h2008);
        build(16'h2008, 40, "R1");
        mon_on = 1;
        while (last_addr != 16'h2009) cyc();
        redirect_valid = 1;
        redirect_addr  = 16'h2040;
        build(16'h2040, 40, "R10");
        cyc();
        redirect_valid = 0;
        while (got < 8) cyc();
        chk(got >= 8, "R10", "instructions after redirect", got, 8);

        // phase 3: strobe latency for one-byte and three-byte first instructions
        do_reset(16'h2003);
        build(16'h2003, 20, "R1");
        mon_on = 1;
        while (first_v < 0) cyc();
        chk(first_v == 2, "R8", "one-byte strobe cycle", first_v, 2);

        do_reset(16'h2008);
        build(16'h2008, 20, "R1");
        mon_on = 1;
        while (first_v < 0) cyc();
        chk(first_v == 6, "R8", "three-byte strobe cycle", first_v, 6);
        mon_on = 0;
    endtask

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 8'h00;
        mem[8'h00] = 8'h3E; mem[8'h01] = 8'h32;
        mem[8'h02] = 8'h4F;
        mem[8'h03] = 8'h2F;
        mem[8'h04] = 8'h06; mem[8'h05] = 8'hF2;
        mem[8'h06] = 8'h0E; mem[8'h07] = 8'h5A;
        mem[8'h08] = 8'h3A; mem[8'h09] = 8'h50; mem[8'h0A] = 8'h20;
        mem[8'h0B] = 8'h41;
        mem[8'h0C] = 8'h76;
        mem[8'h0D] = 8'hFF;
        mem[8'h0E] = 8'h16; mem[8'h0F] = 8'h77;
        mem[8'h10] = 8'hC3; mem[8'h11] = 8'h40; mem[8'h12] = 8'h20;
        mem[8'h13] = 8'hAA;
        mem[8'h40] = 8'h3E; mem[8'h41] = 8'h06;
        mem[8'h42] = 8'h06; mem[8'h43] = 8'h3E;
        mem[8'h44] = 8'h79;
        mem[8'h45] = 8'hC3; mem[8'h46] = 8'h00; mem[8'h47] = 8'h20;

        @(negedge clk);
        fork
            run_main();
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired act=hung exp=done");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule